// File: doc/BRIEF.md
# Card Attribute Memory Slave

This block is the card-side responder for attribute-space cycles on the parallel host bus of a removable storage card. The host qualifies each cycle with a register-space select, two active-low lane enables (even lane and odd lane), a read strobe, a write strobe and a ten-bit attribute address. The block samples these controls through a synchroniser and tracks each cycle with a small state machine. It answers reads from a read-only card information byte table or from a bank of byte-wide configuration registers. Writes into the register bank take effect, and writes anywhere else are dropped.

Address bit 9 picks the region: low selects the information table, high selects the configuration bank, which starts at attribute offset 200h. Only even byte addresses carry data, and the data always sits on the low lane, for single-lane and two-lane cycles alike. A strap input puts the card in IDE-emulation mode. While it is set, the block neither drives the bus nor accepts writes.

The state machine has four states. ST_IDLE waits for a qualified cycle. ST_READ drives the selected lanes. ST_WRITE buffers the write byte and commits it when the synchronised write strobe rises. ST_HOLD parks a cycle that changed direction without a release. The transitions are:
- ST_IDLE to ST_READ on a read request, and ST_IDLE to ST_WRITE on a write request.
- ST_READ to ST_IDLE on release or strap. ST_READ to ST_HOLD when the write strobe falls without a release.
- ST_WRITE to ST_IDLE on commit, abort or strap. ST_WRITE to ST_HOLD when the read strobe falls.
- ST_HOLD to ST_IDLE on release or strap.

Top module: `card_attr_slave`

## Requirements
- R1: A read is served only when the space select is low, at least one lane enable is low, the read strobe is low and the write strobe is high. Any other combination leaves both lanes undriven.
- R2: After reset, and whenever both lane enables are high, neither lane is driven.
- R3: A read with only the even-lane enable low drives the low lane (bits 7:0) and leaves the high lane (bits 15:8) undriven.
- R4: A read with both lane enables low drives both lanes. The low lane carries the data and the high-lane value is unspecified.
- R5: With address bit 9 low and bit 0 low, the low lane returns table byte number addr[8:1]. Byte k is bits 8k+7..8k of the table parameter. Indices at or beyond the table depth return FFh. Any odd address returns FFh.
- R6: With address bit 9 high and bit 0 low, the low lane returns configuration register addr[8:1] when that index is below the register count, and 00h otherwise.
- R7: Configuration registers reset to 00h. A write stores the low-lane byte into register addr[8:1] when the synchronised write strobe rises.
- R8: A write has no effect when it targets the table region, an odd address, a register index at or beyond the count, or a cycle whose even-lane enable is high.
- R9: While the IDE strap is high, neither lane is driven and writes have no effect.
- R10: A cycle that turns from read to write, or from write to read, without first raising both lane enables or both strobes is not served. No lane is driven and nothing is written until a release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ide_strap | input | 1 | High selects IDE-emulation mode |
| space_sel_n | input | 1 | Active-low attribute space select |
| en_even_n | input | 1 | Active-low low-lane enable |
| en_odd_n | input | 1 | Active-low high-lane enable |
| rd_strobe_n | input | 1 | Active-low read strobe |
| wr_strobe_n | input | 1 | Active-low write strobe |
| addr | input | 10 | Attribute byte address |
| wr_data | input | 8 | Low-lane write data |
| rd_data | output | 16 | Read data, both lanes |
| lane_lo_oe | output | 1 | Drive enable for bits 7:0 |
| lane_hi_oe | output | 1 | Drive enable for bits 15:8 |

## Verification
The bench builds the block with a 12-byte information table, four configuration registers and a two-stage synchroniser. The 12-byte table is shorter than the index space, so both the last valid byte (index 11) and the first out-of-range index (12) can be reached. Four registers put the boundary between implemented and unimplemented configuration offsets at 206h and 208h, and random addresses cover both sides. The two-stage synchroniser sets the three-cycle response latency that the bench waits out before it samples.

// File: rtl/card_attr_pkg.sv
package card_attr_pkg;

    // Attribute address width is fixed by the bus: bit 9 is the region select.
    localparam int ATTR_AW = 10;
    localparam int BYTE_W  = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_HOLD
    } attr_state_e;

    // Control bundle carried through the synchroniser.
    typedef struct packed {
        logic ide;
        logic sel_n;
        logic ev_n;
        logic od_n;
        logic rd_n;
        logic wr_n;
    } ctl_bus_t;

    // Inactive bus: strap clear, every active-low control high.
    localparam ctl_bus_t CTL_QUIET = 6'b011111;

endpackage

// File: rtl/card_attr_sync.sv
module card_attr_sync #(
    parameter int             WIDTH   = 6,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= RST_VAL;
            else        chain[g] <= chain[g-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/card_attr_cis_rom.sv
module card_attr_cis_rom #(
    parameter int                  DEPTH = 16,
    parameter logic [DEPTH*8-1:0]  INIT  = '1
) (
    input  logic [7:0] idx,
    output logic [7:0] data
);

    always_comb begin
        if (int'(idx) < DEPTH) data = INIT[int'(idx)*8 +: 8];
        else                   data = 8'hFF;
    end

endmodule

// File: rtl/card_attr_cfg_bank.sv
module card_attr_cfg_bank #(
    parameter int NUM = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] idx,
    input  logic [7:0] wr_byte,
    output logic [7:0] rd_byte
);

    logic [7:0] regs [NUM];

    for (genvar g = 0; g < NUM; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              regs[g] <= 8'h00;
            else if (wr_en && (int'(idx) == g))      regs[g] <= wr_byte;
        end
    end

    always_comb begin
        rd_byte = 8'h00;
        for (int k = 0; k < NUM; k++) begin
            if (int'(idx) == k) rd_byte = regs[k];
        end
    end

endmodule

// File: rtl/card_attr_slave.sv
module card_attr_slave
    import card_attr_pkg::*;
#(
    parameter int                       SYNC_STAGES = 2,
    parameter int                       CIS_DEPTH   = 16,
    parameter logic [CIS_DEPTH*8-1:0]   CIS_INIT    = 128'hFF_14_00_20_03_C0_01_1A_FF_04_02_41_03_01_00_01,
    parameter int                       NUM_CFG     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ide_strap,
    input  logic               space_sel_n,
    input  logic               en_even_n,
    input  logic               en_odd_n,
    input  logic               rd_strobe_n,
    input  logic               wr_strobe_n,
    input  logic [ATTR_AW-1:0] addr,
    input  logic [BYTE_W-1:0]  wr_data,
    output logic [15:0]        rd_data,
    output logic               lane_lo_oe,
    output logic               lane_hi_oe
);

    localparam int CTL_W = $bits(ctl_bus_t);

    // ---------------- synchronised controls ----------------
    ctl_bus_t ctl_raw, ctl_s;
    logic [CTL_W-1:0] ctl_s_vec;

    assign ctl_raw = '{ide:   ide_strap,
                       sel_n: space_sel_n,
                       ev_n:  en_even_n,
                       od_n:  en_odd_n,
                       rd_n:  rd_strobe_n,
                       wr_n:  wr_strobe_n};

    card_attr_sync #(
        .WIDTH   (CTL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (CTL_QUIET)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ctl_raw),
        .q     (ctl_s_vec)
    );

    assign ctl_s = ctl_bus_t'(ctl_s_vec);

    logic ide_s, sel_n_s, ev_n_s, od_n_s, rd_n_s, wr_n_s;
    assign ide_s   = ctl_s.ide;
    assign sel_n_s = ctl_s.sel_n;
    assign ev_n_s  = ctl_s.ev_n;
    assign od_n_s  = ctl_s.od_n;
    assign rd_n_s  = ctl_s.rd_n;
    assign wr_n_s  = ctl_s.wr_n;

    logic any_en, req_rd, req_wr, released;
    assign any_en   = !(ev_n_s && od_n_s);
    assign req_rd   = !ide_s && !sel_n_s && any_en && !rd_n_s &&  wr_n_s;
    assign req_wr   = !ide_s && !sel_n_s && any_en &&  rd_n_s && !wr_n_s;
    assign released = !any_en || sel_n_s || (rd_n_s && wr_n_s);

    // ---------------- state and cycle context ----------------
    attr_state_e        state_q, state_d;
    logic [ATTR_AW-1:0] lat_addr_q;
    logic               lat_ev_q, lat_od_q;
    logic [BYTE_W-1:0]  wbuf_q;
    logic               cfg_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            lat_addr_q <= '0;
            lat_ev_q   <= 1'b0;
            lat_od_q   <= 1'b0;
            wbuf_q     <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && (req_rd || req_wr)) begin
                lat_addr_q <= addr;
                lat_ev_q   <= !ev_n_s;
                lat_od_q   <= !od_n_s;
            end
            if ((state_q == ST_IDLE && req_wr) || (state_q == ST_WRITE && !wr_n_s))
                wbuf_q <= wr_data;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_rd)      state_d = ST_READ;
                else if (req_wr) state_d = ST_WRITE;
            end
            ST_READ: begin
                if (ide_s || released) state_d = ST_IDLE;
                else if (!wr_n_s)      state_d = ST_HOLD;
            end
            ST_WRITE: begin
                if (ide_s || sel_n_s || !any_en) state_d = ST_IDLE;
                else if (wr_n_s && rd_n_s)       state_d = ST_IDLE;
                else if (!rd_n_s)                state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (ide_s || released) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Commit on the synchronised rising write strobe of a live write cycle.
    assign cfg_wr = (state_q == ST_WRITE) && !ide_s && !sel_n_s && any_en &&
                    wr_n_s && rd_n_s && lat_ev_q &&
                    lat_addr_q[9] && !lat_addr_q[0];

    // ---------------- storage ----------------
    logic [7:0] cis_byte, cfg_byte;

    card_attr_cis_rom #(
        .DEPTH (CIS_DEPTH),
        .INIT  (CIS_INIT)
    ) u_cis (
        .idx  (lat_addr_q[8:1]),
        .data (cis_byte)
    );

    card_attr_cfg_bank #(
        .NUM (NUM_CFG)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .idx     (lat_addr_q[8:1]),
        .wr_byte (wbuf_q),
        .rd_byte (cfg_byte)
    );

    // ---------------- outputs ----------------
    logic [7:0] rd_byte;

    always_comb begin
        if (lat_addr_q[0])      rd_byte = 8'hFF;
        else if (lat_addr_q[9]) rd_byte = cfg_byte;
        else                    rd_byte = cis_byte;

        lane_lo_oe = (state_q == ST_READ) && lat_ev_q;
        lane_hi_oe = (state_q == ST_READ) && lat_od_q;
        rd_data    = (state_q == ST_READ) ? {8'hFF, rd_byte} : 16'h0000;
    end

endmodule

// File: rtl/card_attr_checker.sv
module card_attr_checker
    import card_attr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        ide_s,
    input logic        wr_n_s,
    input logic        ev_n_s,
    input logic        od_n_s,
    input attr_state_e state_q,
    input logic        cfg_wr,
    input logic        lane_lo_oe,
    input logic        lane_hi_oe
);

    // R1: a low write strobe ends any driving in the next cycle
    assert_wr_low_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n_s |=> (!lane_lo_oe && !lane_hi_oe));

    // R2: standby leaves both lanes floating next cycle
    assert_standby_float_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_n_s && od_n_s) |=> (!lane_lo_oe && !lane_hi_oe));

    // R7: commit only follows a low write strobe
    assert_commit_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |-> !$past(wr_n_s));

    // R9: strap silences the bus next cycle
    assert_ide_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ide_s |=> (!lane_lo_oe && !lane_hi_oe));

    // R9: no commit under strap
    assert_ide_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ide_s |-> !cfg_wr);

    // R10: a parked cycle never drives in the following cycle
    assert_hold_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> (!lane_lo_oe && !lane_hi_oe));

endmodule

bind card_attr_slave card_attr_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ide_s      (ide_s),
    .wr_n_s     (wr_n_s),
    .ev_n_s     (ev_n_s),
    .od_n_s     (od_n_s),
    .state_q    (state_q),
    .cfg_wr     (cfg_wr),
    .lane_lo_oe (lane_lo_oe),
    .lane_hi_oe (lane_hi_oe)
);

// File: tb/card_attr_slave_tb.sv
`timescale 1ns/1ps
module card_attr_slave_tb_top;

    localparam int               T_DEPTH = 12;
    localparam logic [T_DEPTH*8-1:0] T_INIT = 96'h5A_C3_81_7E_10_20_40_80_11_22_33_44;
    localparam int               T_NCFG  = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ide_strap, space_sel_n, en_even_n, en_odd_n, rd_strobe_n, wr_strobe_n;
    logic [9:0]  addr;
    logic [7:0]  wr_data;
    logic [15:0] rd_data;
    logic        lane_lo_oe, lane_hi_oe;

    always #2.5 clk = ~clk;

    card_attr_slave #(
        .SYNC_STAGES (2),
        .CIS_DEPTH   (T_DEPTH),
        .CIS_INIT    (T_INIT),
        .NUM_CFG     (T_NCFG)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ide_strap   (ide_strap),
        .space_sel_n (space_sel_n),
        .en_even_n   (en_even_n),
        .en_odd_n    (en_odd_n),
        .rd_strobe_n (rd_strobe_n),
        .wr_strobe_n (wr_strobe_n),
        .addr        (addr),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .lane_lo_oe  (lane_lo_oe),
        .lane_hi_oe  (lane_hi_oe)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [7:0] cfg_model [T_NCFG];

    function automatic logic [7:0] exp_byte(input logic [9:0] a);
        int k;
        k = int'(a[8:1]);
        if (a[0])        return 8'hFF;
        if (!a[9])       return (k < T_DEPTH) ? T_INIT[k*8 +: 8] : 8'hFF;
        if (k < T_NCFG)  return cfg_model[k];
        return 8'h00;
    endfunction

    function automatic bit write_lands(input bit ide, input bit ev_n, input logic [9:0] a);
        return !ide && !ev_n && !a[0] && a[9] && (int'(a[8:1]) < T_NCFG);
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quiet_bus();
        @(negedge clk);
        space_sel_n = 1'b1; en_even_n = 1'b1; en_odd_n = 1'b1;
        rd_strobe_n = 1'b1; wr_strobe_n = 1'b1;
        wait_cyc(5);
    endtask

    // Read cycle, checks lane enables and low-lane data.
    task automatic do_read(input string req, input bit ev_n, input bit od_n, input logic [9:0] a);
        bit lo, hi;
        @(negedge clk);
        addr = a; space_sel_n = 1'b0; en_even_n = ev_n; en_odd_n = od_n;
        rd_strobe_n = 1'b0; wr_strobe_n = 1'b1;
        wait_cyc(6);
        lo = !ide_strap && !ev_n;
        hi = !ide_strap && !od_n;
        chk({req, " lo_oe"}, {15'd0, lane_lo_oe}, {15'd0, lo});
        chk({req, " hi_oe"}, {15'd0, lane_hi_oe}, {15'd0, hi});
        if (lo) chk({req, " data"}, {8'h00, rd_data[7:0]}, {8'h00, exp_byte(a)});
        quiet_bus();
    endtask

    task automatic do_write(input bit ev_n, input bit od_n, input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; space_sel_n = 1'b0; en_even_n = ev_n; en_odd_n = od_n;
        rd_strobe_n = 1'b1; wr_strobe_n = 1'b0;
        wait_cyc(6);
        wr_strobe_n = 1'b1;
        wait_cyc(6);
        if (write_lands(ide_strap, ev_n, a)) cfg_model[int'(a[8:1])] = d;
        quiet_bus();
    endtask

    task automatic set_strap(input bit v);
        @(negedge clk);
        ide_strap = v;
        wait_cyc(5);
    endtask

    initial begin
        #(150000 * 5);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0A77);
        for (int i = 0; i < T_NCFG; i++) cfg_model[i] = 8'h00;
        rst_n = 1'b0; ide_strap = 1'b0; space_sel_n = 1'b1; en_even_n = 1'b1; en_odd_n = 1'b1;
        rd_strobe_n = 1'b1; wr_strobe_n = 1'b1; addr = '0; wr_data = '0;
        wait_cyc(4);
        // R2: reset state, nothing driven
        chk("R2 reset lo_oe", {15'd0, lane_lo_oe}, 16'd0);
        chk("R2 reset hi_oe", {15'd0, lane_hi_oe}, 16'd0);
        @(negedge clk) rst_n = 1'b1;
        wait_cyc(4);

        // R1: read strobe without space select is not served
        @(negedge clk);
        addr = 10'h000; space_sel_n = 1'b1; en_even_n = 1'b0; rd_strobe_n = 1'b0;
        wait_cyc(6);
        chk("R1 no select", {14'd0, lane_hi_oe, lane_lo_oe}, 16'd0);
        // R1: both strobes low is not served
        space_sel_n = 1'b0; wr_strobe_n = 1'b0;
        wait_cyc(6);
        chk("R1 both strobes", {14'd0, lane_hi_oe, lane_lo_oe}, 16'd0);
        quiet_bus();

        // R3, R5: single-lane table reads, last valid byte and out of range
        do_read("R3 R5 idx0", 1'b0, 1'b1, 10'h000);
        do_read("R5 idx11", 1'b0, 1'b1, 10'h016);
        do_read("R5 idx12 beyond", 1'b0, 1'b1, 10'h018);
        do_read("R5 odd", 1'b0, 1'b1, 10'h005);
        // R4: two-lane read
        do_read("R4 word", 1'b0, 1'b0, 10'h004);
        // R2: standby with strobes active
        @(negedge clk);
        space_sel_n = 1'b0; rd_strobe_n = 1'b0;
        wait_cyc(6);
        chk("R2 standby", {14'd0, lane_hi_oe, lane_lo_oe}, 16'd0);
        quiet_bus();

        // R7: reset value and write/readback
        do_read("R7 reset value", 1'b0, 1'b1, 10'h202);
        do_write(1'b0, 1'b1, 10'h200, 8'h5A);
        do_read("R7 readback", 1'b0, 1'b1, 10'h200);
        do_write(1'b0, 1'b0, 10'h206, 8'hC3);
        do_read("R7 word write", 1'b0, 1'b0, 10'h206);
        // R6: unimplemented offset reads zero
        do_write(1'b0, 1'b1, 10'h208, 8'hEE);
        do_read("R6 unimpl", 1'b0, 1'b1, 10'h208);
        // R8: table write, odd write, odd-lane-only write are dropped
        do_write(1'b0, 1'b1, 10'h002, 8'h00);
        do_read("R8 table write", 1'b0, 1'b1, 10'h002);
        do_write(1'b0, 1'b1, 10'h201, 8'h99);
        do_read("R8 odd write", 1'b0, 1'b1, 10'h200);
        do_write(1'b1, 1'b0, 10'h202, 8'h66);
        do_read("R8 odd lane only", 1'b0, 1'b1, 10'h202);

        // R9: strap blocks reads and writes
        set_strap(1'b1);
        do_read("R9 strap read", 1'b0, 1'b0, 10'h200);
        do_write(1'b0, 1'b1, 10'h204, 8'h77);
        set_strap(1'b0);
        do_read("R9 after strap", 1'b0, 1'b1, 10'h204);

        // R10: read turns into write without release
        @(negedge clk);
        addr = 10'h200; space_sel_n = 1'b0; en_even_n = 1'b0; en_odd_n = 1'b1;
        rd_strobe_n = 1'b0; wr_strobe_n = 1'b1;
        wait_cyc(6);
        chk("R10 read live", {15'd0, lane_lo_oe}, 16'd1);
        wr_data = 8'h3C; rd_strobe_n = 1'b1; wr_strobe_n = 1'b0;
        wait_cyc(6);
        chk("R10 parked", {14'd0, lane_hi_oe, lane_lo_oe}, 16'd0);
        wr_strobe_n = 1'b1;
        wait_cyc(6);
        quiet_bus();
        do_read("R10 no commit", 1'b0, 1'b1, 10'h200);

        // Random mix
        for (int t = 0; t < 300; t++) begin
            logic [9:0] a;
            bit ev_n, od_n, strap;
            a = {$urandom_range(1) ? 1'b1 : 1'b0, 4'b0000, 4'($urandom_range(15)), 1'b0};
            if ($urandom_range(7) == 0) a[0] = 1'b1;
            if ($urandom_range(9) == 0) a[8:5] = 4'($urandom_range(15));
            ev_n  = ($urandom_range(3) == 0);
            od_n  = ($urandom_range(1) == 0);
            strap = ($urandom_range(9) == 0);
            if (strap) set_strap(1'b1);
            if ($urandom_range(1)) do_write(ev_n, od_n, a, 8'($urandom_range(255)));
            else                   do_read("R5 R6 R7 random", ev_n, od_n, a);
            if (strap) set_strap(1'b0);
        end
        for (int i = 0; i < T_NCFG; i++) do_read("R7 final", 1'b0, 1'b1, 10'h200 + 10'(2*i));

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule